// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a free-running precision-time clock. On every clock edge it adds a programmable period to its time. The period is a 32-bit value made of 16 bits of whole nanoseconds and 16 bits of binary nanosecond fraction. The main time is a mixed-radix count with three fields: seconds, nanoseconds and fraction. The fraction carries into the nanoseconds, and the nanoseconds roll over at one billion and carry into the seconds. All of these carries settle within one cycle.

A second, independent accumulator counts elapsed time as one binary nanosecond-and-fraction number. It is 48 bits of nanoseconds above 16 bits of fraction, so it never rolls over at a second boundary. This suits latency and correction arithmetic.

A third output is derived from the main time with no state of its own. It is the low 32 bits of the seconds next to the 32-bit nanoseconds, with the fraction dropped. Software can replace the main time or the accumulator with a load strobe, and each strobe acts on the next edge. The data pins are plain control and status: the counter always advances, so there is no flow control and no back-pressure.

Top module: `ptp_tod_clock`

## Requirements
- R1: While `rst_n` is low, every output reads zero.
- R2: When `tod_load_i` is low, each clock edge adds `incr_i` to `tod96_o`. The nanoseconds part of `incr_i` is bits [31:16] and the fraction part is bits [15:0]. Bits [15:0] of `tod96_o` are the fraction, and a fraction sum above 0xFFFF carries one into the nanoseconds field.
- R3: The nanoseconds field of `tod96_o` (bits [47:16]) is always below 1,000,000,000. A sum that reaches that value is reduced by 1,000,000,000, and the seconds field (bits [95:48]) grows by one.
- R4: When `span_load_i` is low, each clock edge adds `incr_i` to `span64_o` as a plain 64-bit binary sum. Its 48-bit nanosecond count is bits [63:16] and its fraction is bits [15:0]. The count does not roll over at one second and can exceed 2^32 ns.
- R5: `tod64_o` equals bits [79:48] of `tod96_o` (the low 32 seconds bits) in bits [63:32], and bits [47:16] of `tod96_o` (the nanoseconds) in bits [31:0]. Both outputs update on the same edge.
- R6: A high `tod_load_i` with a nanoseconds field below one billion makes `tod96_o` equal `tod_load_val_i` after the next edge. The increment is ignored for that edge, and `span64_o` still advances by `incr_i`.
- R7: A load whose nanoseconds field (bits [47:16] of `tod_load_val_i`) is 1,000,000,000 or more stores 999,999,999 in place of that field. The seconds and fraction are stored unchanged.
- R8: A high `span_load_i` makes `span64_o` equal `span_load_val_i` after the next edge and leaves `tod96_o` untouched.
- R9: A zero increment holds `tod96_o` unchanged.
- R10: The seconds field wraps from 2^48-1 to 0 when a nanosecond rollover carries into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| incr_i | input | 32 | Period added per cycle: nanoseconds [31:16], fraction [15:0] |
| tod_load_i | input | 1 | Load strobe for the 96-bit time |
| tod_load_val_i | input | 96 | Time to load: seconds [95:48], nanoseconds [47:16], fraction [15:0] |
| span_load_i | input | 1 | Load strobe for the nanosecond accumulator |
| span_load_val_i | input | 64 | Accumulator value to load: nanoseconds [63:16], fraction [15:0] |
| tod96_o | output | 96 | Time: seconds [95:48], nanoseconds [47:16], fraction [15:0] |
| span64_o | output | 64 | Elapsed count: nanoseconds [63:16], fraction [15:0] |
| tod64_o | output | 64 | Short time: seconds [63:32], nanoseconds [31:0] |

## Verification
The checker assumes that every input holds a known value at each rising edge once reset is released. It also assumes that both load strobes stay low while reset is low. It makes no assumption about the range of the increment or of a loaded nanoseconds field, because the design has to handle full-scale increments and out-of-range loads. The bench changes its inputs only on falling edges and keeps both strobes low during reset. It deliberately drives loads of exactly one billion and of all-ones nanoseconds, so the clamp path runs under the same checks as legal loads.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Field widths fixed by the three time encodings.
  localparam int TOD_SEC_W       = 48;
  localparam int TOD_NS_W        = 32;
  localparam int TOD_FRAC_W      = 16;
  localparam int TOD_INC_NS_W    = 16;
  localparam int TOD_SPAN_NS_W   = 48;
  localparam int TOD_SHORT_SEC_W = 32;
  localparam logic [63:0] TOD_NS_ROLL = 64'd1_000_000_000;
endpackage

// File: rtl/tod_frac_ns_step.sv
module tod_frac_ns_step #(
  parameter int          NS_W     = 32,
  parameter int          FRAC_W   = 16,
  parameter int          INC_NS_W = 16,
  parameter logic [63:0] NS_ROLL  = 64'd1_000_000_000
) (
  input  logic [NS_W-1:0]     ns_i,
  input  logic [FRAC_W-1:0]   frac_i,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [FRAC_W-1:0]   inc_frac_i,
  output logic [NS_W-1:0]     ns_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                sec_carry_o
);
  localparam logic [NS_W:0] ROLL = NS_ROLL[NS_W:0];

  logic [FRAC_W:0] frac_sum;
  logic [NS_W:0]   ns_sum;
  logic [NS_W:0]   ns_wrapped;

  // One subtraction is enough: the largest sum is below two billion.
  always_comb begin
    frac_sum    = {1'b0, frac_i} + {1'b0, inc_frac_i};
    ns_sum      = {1'b0, ns_i} + (NS_W+1)'(inc_ns_i) + (NS_W+1)'(frac_sum[FRAC_W]);
    ns_wrapped  = ns_sum - ROLL;
    sec_carry_o = (ns_sum >= ROLL);
    ns_o        = sec_carry_o ? ns_wrapped[NS_W-1:0] : ns_sum[NS_W-1:0];
    frac_o      = frac_sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/tod_load_clamp.sv
module tod_load_clamp #(
  parameter int          NS_W    = 32,
  parameter logic [63:0] NS_ROLL = 64'd1_000_000_000
) (
  input  logic [NS_W-1:0] ns_i,
  output logic [NS_W-1:0] ns_o
);
  localparam logic [63:0]     ROLL_M1  = NS_ROLL - 64'd1;
  localparam logic [NS_W-1:0] NS_LIMIT = ROLL_M1[NS_W-1:0];

  always_comb begin
    ns_o = (ns_i > NS_LIMIT) ? NS_LIMIT : ns_i;
  end
endmodule

// File: rtl/tod_main_counter.sv
module tod_main_counter #(
  parameter int          SEC_W    = 48,
  parameter int          NS_W     = 32,
  parameter int          FRAC_W   = 16,
  parameter int          INC_NS_W = 16,
  parameter logic [63:0] NS_ROLL  = 64'd1_000_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INC_NS_W-1:0] inc_ns_i,
  input  logic [FRAC_W-1:0]   inc_frac_i,
  input  logic                load_i,
  input  logic [SEC_W-1:0]    load_sec_i,
  input  logic [NS_W-1:0]     load_ns_i,
  input  logic [FRAC_W-1:0]   load_frac_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [NS_W-1:0]     ns_o,
  output logic [FRAC_W-1:0]   frac_o
);
  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic [NS_W-1:0]   ns_step;
  logic [FRAC_W-1:0] frac_step;
  logic              sec_carry;
  logic [NS_W-1:0]   ns_loaded;

  tod_frac_ns_step #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_NS_W(INC_NS_W), .NS_ROLL(NS_ROLL)
  ) u_step (
    .ns_i       (ns_q),
    .frac_i     (frac_q),
    .inc_ns_i   (inc_ns_i),
    .inc_frac_i (inc_frac_i),
    .ns_o       (ns_step),
    .frac_o     (frac_step),
    .sec_carry_o(sec_carry)
  );

  tod_load_clamp #(
    .NS_W(NS_W), .NS_ROLL(NS_ROLL)
  ) u_clamp (
    .ns_i(load_ns_i),
    .ns_o(ns_loaded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      sec_q  <= load_sec_i;
      ns_q   <= ns_loaded;
      frac_q <= load_frac_i;
    end else begin
      sec_q  <= sec_q + SEC_W'(sec_carry);
      ns_q   <= ns_step;
      frac_q <= frac_step;
    end
  end

  assign sec_o  = sec_q;
  assign ns_o   = ns_q;
  assign frac_o = frac_q;
endmodule

// File: rtl/tod_span_counter.sv
module tod_span_counter #(
  parameter int SPAN_W = 64,
  parameter int INC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              load_i,
  input  logic [SPAN_W-1:0] load_val_i,
  output logic [SPAN_W-1:0] span_o
);
  logic [SPAN_W-1:0] span_q;

  // The fraction sits in the low bits, so its carry is an ordinary binary carry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
    end else if (load_i) begin
      span_q <= load_val_i;
    end else begin
      span_q <= span_q + SPAN_W'(inc_i);
    end
  end

  assign span_o = span_q;
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import tod_pkg::*;
#(
  parameter int          SEC_W       = TOD_SEC_W,
  parameter int          NS_W        = TOD_NS_W,
  parameter int          FRAC_W      = TOD_FRAC_W,
  parameter int          INC_NS_W    = TOD_INC_NS_W,
  parameter int          SPAN_NS_W   = TOD_SPAN_NS_W,
  parameter int          SHORT_SEC_W = TOD_SHORT_SEC_W,
  parameter logic [63:0] NS_ROLL     = TOD_NS_ROLL,
  localparam int TOD_W   = SEC_W + NS_W + FRAC_W,
  localparam int SPAN_W  = SPAN_NS_W + FRAC_W,
  localparam int INC_W   = INC_NS_W + FRAC_W,
  localparam int SHORT_W = SHORT_SEC_W + NS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INC_W-1:0]   incr_i,
  input  logic               tod_load_i,
  input  logic [TOD_W-1:0]   tod_load_val_i,
  input  logic               span_load_i,
  input  logic [SPAN_W-1:0]  span_load_val_i,
  output logic [TOD_W-1:0]   tod96_o,
  output logic [SPAN_W-1:0]  span64_o,
  output logic [SHORT_W-1:0] tod64_o
);
  localparam int NS_LO = FRAC_W;
  localparam int NS_HI = FRAC_W + NS_W - 1;
  localparam int SEC_LO = FRAC_W + NS_W;

  logic [SEC_W-1:0]  sec;
  logic [NS_W-1:0]   ns;
  logic [FRAC_W-1:0] frac;

  tod_main_counter #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
    .INC_NS_W(INC_NS_W), .NS_ROLL(NS_ROLL)
  ) u_main (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_ns_i   (incr_i[INC_W-1:FRAC_W]),
    .inc_frac_i (incr_i[FRAC_W-1:0]),
    .load_i     (tod_load_i),
    .load_sec_i (tod_load_val_i[TOD_W-1:SEC_LO]),
    .load_ns_i  (tod_load_val_i[NS_HI:NS_LO]),
    .load_frac_i(tod_load_val_i[FRAC_W-1:0]),
    .sec_o      (sec),
    .ns_o       (ns),
    .frac_o     (frac)
  );

  tod_span_counter #(
    .SPAN_W(SPAN_W), .INC_W(INC_W)
  ) u_span (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (incr_i),
    .load_i    (span_load_i),
    .load_val_i(span_load_val_i),
    .span_o    (span64_o)
  );

  // Both encodings of the time come from the same registers.
  assign tod96_o = {sec, ns, frac};
  assign tod64_o = {sec[SHORT_SEC_W-1:0], ns};
endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk #(
  parameter int          SEC_W       = 48,
  parameter int          NS_W        = 32,
  parameter int          FRAC_W      = 16,
  parameter int          INC_NS_W    = 16,
  parameter int          SPAN_NS_W   = 48,
  parameter int          SHORT_SEC_W = 32,
  parameter logic [63:0] NS_ROLL     = 64'd1_000_000_000,
  localparam int TOD_W   = SEC_W + NS_W + FRAC_W,
  localparam int SPAN_W  = SPAN_NS_W + FRAC_W,
  localparam int INC_W   = INC_NS_W + FRAC_W,
  localparam int SHORT_W = SHORT_SEC_W + NS_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [INC_W-1:0]   incr_i,
  input logic               tod_load_i,
  input logic [TOD_W-1:0]   tod_load_val_i,
  input logic               span_load_i,
  input logic [SPAN_W-1:0]  span_load_val_i,
  input logic [TOD_W-1:0]   tod96_o,
  input logic [SPAN_W-1:0]  span64_o,
  input logic [SHORT_W-1:0] tod64_o
);
  localparam int NS_LO  = FRAC_W;
  localparam int NS_HI  = FRAC_W + NS_W - 1;
  localparam int SEC_LO = FRAC_W + NS_W;
  localparam logic [NS_W-1:0] ROLL    = NS_ROLL[NS_W-1:0];
  localparam logic [NS_W-1:0] ROLL_M1 = ROLL - 1'b1;

  logic [FRAC_W-1:0] frac_next;
  logic [SEC_W-1:0]  sec_now;
  logic [SEC_W-1:0]  sec_plus1;
  logic [SPAN_W-1:0] span_next;
  logic [NS_W-1:0]   load_ns;

  assign frac_next = tod96_o[FRAC_W-1:0] + incr_i[FRAC_W-1:0];
  assign sec_now   = tod96_o[TOD_W-1:SEC_LO];
  assign sec_plus1 = sec_now + 1'b1;
  assign span_next = span64_o + SPAN_W'(incr_i);
  assign load_ns   = tod_load_val_i[NS_HI:NS_LO];

  AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tod_load_i |=> tod96_o[FRAC_W-1:0] == $past(frac_next)); // R2

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tod96_o[NS_HI:NS_LO] < ROLL); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tod_load_i |=> (sec_now == $past(sec_now) || sec_now == $past(sec_plus1))); // R3

  AST_SPAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !span_load_i |=> span64_o == $past(span_next)); // R4

  AST_SHORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tod64_o == {tod96_o[SEC_LO+SHORT_SEC_W-1:SEC_LO], tod96_o[NS_HI:NS_LO]}); // R5

  AST_TOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_load_i && load_ns < ROLL) |=> tod96_o == $past(tod_load_val_i)); // R6

  AST_TOD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_load_i && load_ns >= ROLL) |=> tod96_o[NS_HI:NS_LO] == ROLL_M1); // R7

  AST_SPAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    span_load_i |=> span64_o == $past(span_load_val_i)); // R8
endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_NS_W(INC_NS_W),
  .SPAN_NS_W(SPAN_NS_W), .SHORT_SEC_W(SHORT_SEC_W), .NS_ROLL(NS_ROLL)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .incr_i         (incr_i),
  .tod_load_i     (tod_load_i),
  .tod_load_val_i (tod_load_val_i),
  .span_load_i    (span_load_i),
  .span_load_val_i(span_load_val_i),
  .tod96_o        (tod96_o),
  .span64_o       (span64_o),
  .tod64_o        (tod64_o)
);

// File: tb/ptp_tod_clock_tb_top.sv
module ptp_tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] incr_i = '0;
  logic        tod_load_i = 1'b0;
  logic [95:0] tod_load_val_i = '0;
  logic        span_load_i = 1'b0;
  logic [63:0] span_load_val_i = '0;
  logic [95:0] tod96_o;
  logic [63:0] span64_o;
  logic [63:0] tod64_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  ptp_tod_clock dut_i (
    .clk(clk), .rst_n(rst_n), .incr_i(incr_i),
    .tod_load_i(tod_load_i), .tod_load_val_i(tod_load_val_i),
    .span_load_i(span_load_i), .span_load_val_i(span_load_val_i),
    .tod96_o(tod96_o), .span64_o(span64_o), .tod64_o(tod64_o)
  );

  // Vector: start sec[223:176] ns[175:144] frac[143:128], incr[127:96], expected time[95:0]
  localparam int NV = 7;
  localparam logic [223:0] VEC [NV] = '{
    {48'd0, 32'd0, 16'h0000, 32'h0008_0000, 48'd0, 32'd8, 16'h0000},
    {48'd5, 32'd100, 16'hFFFF, 32'h0000_0001, 48'd5, 32'd101, 16'h0000},
    {48'd7, 32'd999_999_995, 16'h0000, 32'h0008_0000, 48'd8, 32'd3, 16'h0000},
    {48'd2, 32'd999_999_999, 16'h8000, 32'h0000_8000, 48'd3, 32'd0, 16'h0000},
    {48'hFFFF_FFFF_FFFF, 32'd999_999_990, 16'h0000, 32'h000A_0000, 48'd0, 32'd0, 16'h0000},
    {48'd3, 32'd42, 16'h1234, 32'h0000_0000, 48'd3, 32'd42, 16'h1234},
    {48'd1, 32'd0, 16'h0001, 32'hFFFF_FFFF, 48'd1, 32'd65536, 16'h0000}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R3", "R3", "R10", "R9", "R2"};

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", tod96_o, 96'd0);
    check("R1", {32'd0, span64_o}, 96'd0);
    check("R1", {32'd0, tod64_o}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: load start, apply one increment, compare.
    for (int i = 0; i < NV; i++) begin
      tod_load_i     = 1'b1;
      tod_load_val_i = VEC[i][223:128];
      incr_i         = '0;
      @(negedge clk);
      tod_load_i = 1'b0;
      incr_i     = VEC[i][127:96];
      @(negedge clk);
      incr_i = '0;
      check(VTAG[i], tod96_o, VEC[i][95:0]);
      check("R5", {32'd0, tod64_o}, {32'd0, VEC[i][79:48], VEC[i][47:16]});
    end

    // R2: several cycles in a row
    tod_load_i = 1'b1; tod_load_val_i = '0;
    @(negedge clk);
    tod_load_i = 1'b0; incr_i = 32'h0008_4000;
    repeat (3) @(negedge clk);
    incr_i = '0;
    check("R2", tod96_o, {48'd0, 32'd24, 16'hC000});

    // R4: accumulator passes one second without wrapping
    span_load_i = 1'b1; span_load_val_i = {48'd999_999_996, 16'h0};
    @(negedge clk);
    span_load_i = 1'b0; incr_i = 32'h0008_0000;
    @(negedge clk);
    incr_i = '0;
    check("R4", {32'd0, span64_o}, {32'd0, 48'd1_000_000_004, 16'h0});

    // R4: fraction carry and a count above 2^32 ns
    span_load_i = 1'b1; span_load_val_i = {48'hFFFF_FFFC, 16'h8000};
    @(negedge clk);
    span_load_i = 1'b0; incr_i = 32'h0003_8000;
    @(negedge clk);
    incr_i = '0;
    check("R4", {32'd0, span64_o}, {32'd0, 48'h1_0000_0000, 16'h0});

    // R8: accumulator load leaves the time alone
    tod_load_i = 1'b1; tod_load_val_i = {48'd9, 32'd500, 16'h0001};
    @(negedge clk);
    tod_load_i = 1'b0;
    span_load_i = 1'b1; span_load_val_i = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    span_load_i = 1'b0;
    check("R8", {32'd0, span64_o}, {32'd0, 64'h0123_4567_89AB_CDEF});
    check("R8", tod96_o, {48'd9, 32'd500, 16'h0001});

    // R6: load wins over the increment; accumulator still advances
    incr_i = 32'h0008_0000;
    tod_load_i = 1'b1; tod_load_val_i = {48'd77, 32'd123, 16'h0004};
    @(negedge clk);
    tod_load_i = 1'b0; incr_i = '0;
    check("R6", tod96_o, {48'd77, 32'd123, 16'h0004});
    check("R6", {32'd0, span64_o}, {32'd0, 64'h0123_4567_89B3_CDEF});

    // R7: out-of-range nanoseconds are clamped
    tod_load_i = 1'b1; tod_load_val_i = {48'd4, 32'd1_000_000_000, 16'h0005};
    @(negedge clk);
    check("R7", tod96_o, {48'd4, 32'd999_999_999, 16'h0005});
    tod_load_val_i = {48'd6, 32'hFFFF_FFFF, 16'h0007};
    @(negedge clk);
    tod_load_i = 1'b0;
    check("R7", tod96_o, {48'd6, 32'd999_999_999, 16'h0007});
    check("R5", {32'd0, tod64_o}, {32'd0, 32'd6, 32'd999_999_999});

    finish_run();
  end
endmodule